// File: doc/BRIEF.md
# Processor-to-Memory Transfer Bridge

This block sits between a processor's single internal data bus and an external memory bus. It holds the outgoing address in an address register and the transferred word in a data register. Both are moved by control signals that a step sequencer raises for one clock each. The address register is loaded only from the internal bus and always drives the external address lines. The data register has two input paths, internal bus and external read data. It also has two output paths, internal bus and external write data, and each path has its own enable.

A read or write request opens an external transfer. The block raises the matching command line and holds it until memory returns a one-cycle completion flag. Memory may take any number of cycles to do this. While a transfer is open, `busy` stays high so the sequencer can freeze its step counter.

A read is issued as follows: load the address, request the read, wait for `busy` to fall, capture the external data, then drive the word onto the internal bus. A write is issued as follows: load the address, load the word and request the write in one step, then drive the word outward until `busy` falls.

Top module: `mem_bridge`

## Requirements
- R1: With `addr_ld` high at a clock edge, `ext_addr` takes the low AW bits of `ibus_in` after that edge. Otherwise `ext_addr` holds its value.
- R2: With `dr_ld_int` high at an edge, and `dr_drv_int` and `dr_ld_ext` low, the data register takes `ibus_in`. With no load enable it holds. `ext_wdata` always shows the data register.
- R3: With `dr_ld_ext` high at an edge, the data register takes `ext_rdata`. This path wins over `dr_ld_int` when both are high.
- R4: With `dr_drv_int` high and `dr_ld_int` low, `ibus_oe` is 1 and `ibus_out` equals the data register in the same cycle. Otherwise `ibus_out` is 0. `ext_wdata_oe` follows `dr_drv_ext` in the same cycle.
- R5: If `dr_ld_int` and `dr_drv_int` are both high in a cycle, the data register neither loads from the internal bus nor drives it. `ctl_err` is 1 for the following cycle only.
- R6: A lone `rd_req` while `busy` is low makes `busy` and `ext_rd` 1 from the next cycle. Both stay 1 until the edge that samples `mfc` high, and then both return to 0.
- R7: A lone `wr_req` while `busy` is low does the same with `ext_wr` in place of `ext_rd`. `ext_rd` and `ext_wr` are never 1 together.
- R8: `mfc` is sampled at clock edges. A transfer whose flag arrives L cycles after the command appears keeps `busy` high for L+1 cycles, and L may be 1. `mfc` while idle has no effect.
- R9: A request while `busy` is high, or `rd_req` and `wr_req` together while idle, is ignored. `req_err` is 1 for the following cycle only.
- R10: After reset, `ext_addr`, `ext_wdata`, `busy`, `ext_rd`, `ext_wr`, `ctl_err` and `req_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ibus_in | input | DW | Value currently on the internal bus |
| addr_ld | input | 1 | Load the address register from the internal bus |
| dr_ld_int | input | 1 | Load the data register from the internal bus |
| dr_drv_int | input | 1 | Drive the data register onto the internal bus |
| dr_ld_ext | input | 1 | Load the data register from external read data |
| dr_drv_ext | input | 1 | Drive the data register onto external write data |
| rd_req | input | 1 | Start an external read |
| wr_req | input | 1 | Start an external write |
| ibus_out | output | DW | Data register value when driving the internal bus, else 0 |
| ibus_oe | output | 1 | Internal bus drive enable |
| ext_addr | output | AW | External address lines |
| ext_rd | output | 1 | External read command |
| ext_wr | output | 1 | External write command |
| ext_wdata | output | DW | External write data (data register) |
| ext_wdata_oe | output | 1 | External write data drive enable |
| ext_rdata | input | DW | External read data |
| mfc | input | 1 | Memory completion flag |
| busy | output | 1 | Transfer open; sequencer must stall |
| ctl_err | output | 1 | Conflicting internal-bus enables seen last cycle |
| req_err | output | 1 | Rejected request seen last cycle |

## Verification
The assertions check several rules on every cycle. The address register must follow its load enable, the internal drive must be withheld during an enable conflict, and the two error flags must follow their causes. The two commands must never overlap, `busy` must stay high until a completion is sampled, and it must fall right after one. Only the bench scenarios can show that the busy window grows with memory latency, including the one-cycle case. They also show that read data makes the full trip from memory to the internal bus, that written data lands at the right address, and that a completion flag raised while idle changes nothing.

// File: rtl/mb_pkg.sv
// Shared types for the memory transfer bridge.
// Assumes: nothing beyond a two-bit state encoding.
package mb_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RD   = 2'd1,
        XS_WR   = 2'd2
    } xfer_st_t;
endpackage

// File: rtl/mb_addr_reg.sv
// Address register: loads from the internal bus, drives external address lines.
// Assumes: when AW exceeds DW the upper address bits are filled with zero.
module mb_addr_reg #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ibus_in,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] next_addr;

    // Pick the bus bits that form an address, by width relation.
    generate
        if (AW <= DW) begin : g_slice
            assign next_addr = ibus_in[AW-1:0];
        end else begin : g_extend
            assign next_addr = {{(AW-DW){1'b0}}, ibus_in};
        end
    endgenerate

    // Hold the address until the sequencer loads a new one.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_o <= '0;
        else if (load) addr_o <= next_addr;
    end
endmodule

// File: rtl/mb_data_reg.sv
// Data register with two input and two output paths.
// Assumes: the external load wins over the internal load; an internal
// load/drive conflict cancels both internal actions and flags an error.
module mb_data_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_int,
    input  logic          drv_int,
    input  logic          ld_ext,
    input  logic [DW-1:0] ibus_in,
    input  logic [DW-1:0] ext_rdata,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] ibus_out,
    output logic          ibus_oe,
    output logic          ctl_err
);
    logic clash;

    // Detect both internal-bus enables raised in one step.
    assign clash = ld_int & drv_int;

    // Update the stored word from the selected input path.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_o <= '0;
        else if (ld_ext)           data_o <= ext_rdata;
        else if (ld_int && !clash) data_o <= ibus_in;
    end

    // Register the conflict as a one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_err <= 1'b0;
        else        ctl_err <= clash;
    end

    // Drive the internal bus only when the step is unambiguous.
    always_comb begin
        ibus_oe  = drv_int & ~ld_int;
        ibus_out = ibus_oe ? data_o : '0;
    end
endmodule

// File: rtl/mb_xfer_ctl.sv
// Transfer controller: opens a read or write and waits for completion.
// Assumes: mfc is synchronous to clk and sampled only while a transfer is open.
module mb_xfer_ctl
    import mb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic mfc,
    output logic busy,
    output logic ext_rd,
    output logic ext_wr,
    output logic req_err
);
    xfer_st_t st_q;
    logic     any_req;
    logic     bad_req;

    // Classify the incoming request against the current state.
    always_comb begin
        any_req = rd_req | wr_req;
        bad_req = (st_q != XS_IDLE) ? any_req : (rd_req & wr_req);
    end

    // Advance the transfer state; close on a sampled completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= XS_IDLE;
        end else begin
            unique case (st_q)
                XS_IDLE: begin
                    if (rd_req && !wr_req)      st_q <= XS_RD;
                    else if (wr_req && !rd_req) st_q <= XS_WR;
                end
                XS_RD, XS_WR: begin
                    if (mfc) st_q <= XS_IDLE;
                end
                default: st_q <= XS_IDLE;
            endcase
        end
    end

    // Register the rejected-request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= bad_req;
    end

    // Decode the command lines from the state.
    always_comb begin
        busy   = (st_q != XS_IDLE);
        ext_rd = (st_q == XS_RD);
        ext_wr = (st_q == XS_WR);
    end
endmodule

// File: rtl/mem_bridge.sv
// Top of the memory transfer bridge: address register, data register and
// transfer controller joined between the internal and external buses.
// Assumes: one sequencer owns every control input; reset is synchronous.
module mem_bridge #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ibus_in,
    input  logic          addr_ld,
    input  logic          dr_ld_int,
    input  logic          dr_drv_int,
    input  logic          dr_ld_ext,
    input  logic          dr_drv_ext,
    input  logic          rd_req,
    input  logic          wr_req,
    output logic [DW-1:0] ibus_out,
    output logic          ibus_oe,
    output logic [AW-1:0] ext_addr,
    output logic          ext_rd,
    output logic          ext_wr,
    output logic [DW-1:0] ext_wdata,
    output logic          ext_wdata_oe,
    input  logic [DW-1:0] ext_rdata,
    input  logic          mfc,
    output logic          busy,
    output logic          ctl_err,
    output logic          req_err
);
    mb_addr_reg #(.AW(AW), .DW(DW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_ld),
        .ibus_in (ibus_in),
        .addr_o  (ext_addr)
    );

    mb_data_reg #(.DW(DW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_int    (dr_ld_int),
        .drv_int   (dr_drv_int),
        .ld_ext    (dr_ld_ext),
        .ibus_in   (ibus_in),
        .ext_rdata (ext_rdata),
        .data_o    (ext_wdata),
        .ibus_out  (ibus_out),
        .ibus_oe   (ibus_oe),
        .ctl_err   (ctl_err)
    );

    mb_xfer_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .mfc     (mfc),
        .busy    (busy),
        .ext_rd  (ext_rd),
        .ext_wr  (ext_wr),
        .req_err (req_err)
    );

    // Outward drive enable is a direct step control.
    assign ext_wdata_oe = dr_drv_ext;
endmodule

// File: rtl/mb_checks.sv
// Property checker for the memory transfer bridge, bound to mem_bridge.
// Assumes: AW <= DW, as in the default configuration.
module mb_checks #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ibus_in,
    input logic          addr_ld,
    input logic          dr_ld_int,
    input logic          dr_drv_int,
    input logic          rd_req,
    input logic          wr_req,
    input logic          ibus_oe,
    input logic [AW-1:0] ext_addr,
    input logic          ext_rd,
    input logic          ext_wr,
    input logic          mfc,
    input logic          busy,
    input logic          ctl_err,
    input logic          req_err
);
    p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> ext_addr == $past(ibus_in[AW-1:0]));
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ld |=> $stable(ext_addr));
    p_no_drive_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ibus_oe |-> !dr_ld_int);
    p_clash_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_ld_int && dr_drv_int) |=> ctl_err);
    p_rd_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_req && !wr_req) |=> (busy && ext_rd));
    p_wr_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_req && !rd_req) |=> (busy && ext_wr));
    p_cmd_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mfc) |=> busy);
    p_done_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mfc) |=> !busy);
    p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (rd_req || wr_req)) |=> req_err);
endmodule

bind mem_bridge mb_checks #(.AW(AW), .DW(DW)) u_mb_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .ibus_in    (ibus_in),
    .addr_ld    (addr_ld),
    .dr_ld_int  (dr_ld_int),
    .dr_drv_int (dr_drv_int),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .ibus_oe    (ibus_oe),
    .ext_addr   (ext_addr),
    .ext_rd     (ext_rd),
    .ext_wr     (ext_wr),
    .mfc        (mfc),
    .busy       (busy),
    .ctl_err    (ctl_err),
    .req_err    (req_err)
);

// File: tb/test_mem_bridge.sv
module test_mem_bridge;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] ibus_in = '0;
    logic addr_ld = 0, dr_ld_int = 0, dr_drv_int = 0, dr_ld_ext = 0, dr_drv_ext = 0;
    logic rd_req = 0, wr_req = 0;
    logic [DW-1:0] ibus_out, ext_wdata, ext_rdata;
    logic [AW-1:0] ext_addr;
    logic ibus_oe, ext_rd, ext_wr, ext_wdata_oe, mfc, busy, ctl_err, req_err;

    logic          mfc_mdl = 0, mfc_inj = 0, use_tbl = 0;
    logic [DW-1:0] tbl_rdata = '0;
    logic [DW-1:0] mem [256];
    int            lat = 1, cnt = 0;
    int            n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    mem_bridge #(.AW(AW), .DW(DW)) i_mem_bridge (
        .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .addr_ld(addr_ld),
        .dr_ld_int(dr_ld_int), .dr_drv_int(dr_drv_int), .dr_ld_ext(dr_ld_ext),
        .dr_drv_ext(dr_drv_ext), .rd_req(rd_req), .wr_req(wr_req),
        .ibus_out(ibus_out), .ibus_oe(ibus_oe), .ext_addr(ext_addr),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
        .ext_wdata_oe(ext_wdata_oe), .ext_rdata(ext_rdata), .mfc(mfc),
        .busy(busy), .ctl_err(ctl_err), .req_err(req_err)
    );

    // Behavioural memory: completion after lat cycles of an open command.
    assign mfc       = mfc_mdl | mfc_inj;
    assign ext_rdata = use_tbl ? tbl_rdata : mem[ext_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            mfc_mdl <= 0; cnt <= 0;
        end else if ((ext_rd || ext_wr) && !mfc_mdl) begin
            if (cnt == lat - 1) begin mfc_mdl <= 1; cnt <= 0; end
            else cnt <= cnt + 1;
        end else begin
            mfc_mdl <= 0;
        end
        if (rst_n && mfc_mdl && ext_wr && ext_wdata_oe) mem[ext_addr] <= ext_wdata;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk); #2;
    endtask

    // Vector: {addr_ld,ld_int,drv_int,ld_ext,drv_ext}, din, rdata, exp addr, exp data, exp ctl_err
    localparam logic [37:0] VEC [8] = '{
        {5'b10000, 8'h3C, 8'h00, 8'h3C, 8'h00, 1'b0},
        {5'b01000, 8'hA5, 8'h00, 8'h3C, 8'hA5, 1'b0},
        {5'b00000, 8'hFF, 8'h00, 8'h3C, 8'hA5, 1'b0},
        {5'b00010, 8'h00, 8'h5A, 8'h3C, 8'h5A, 1'b0},
        {5'b01010, 8'h11, 8'h22, 8'h3C, 8'h22, 1'b0},
        {5'b01100, 8'h77, 8'h00, 8'h3C, 8'h22, 1'b1},
        {5'b11000, 8'hC3, 8'h00, 8'hC3, 8'hC3, 1'b0},
        {5'b00001, 8'h99, 8'h00, 8'hC3, 8'hC3, 1'b0}
    };

    task automatic do_read(input logic [7:0] a, input int l);
        int n;
        lat = l;
        @(negedge clk); ibus_in = a; addr_ld = 1;
        @(negedge clk); addr_ld = 0; rd_req = 1;
        settle();
        check("R6 busy after read request", busy, 1);
        check("R6 ext_rd after read request", ext_rd, 1);
        @(negedge clk); rd_req = 0;
        n = 1;
        for (int k = 0; k < 50; k++) begin
            settle();
            if (busy) n++; else break;
        end
        check("R8 busy length read", n, l + 1);
        check("R6 ext_rd dropped", ext_rd, 0);
        @(negedge clk); dr_ld_ext = 1;
        @(negedge clk); dr_ld_ext = 0; dr_drv_int = 1; #1;
        check("R4 ibus_oe on drive", ibus_oe, 1);
        check("R3 read data to internal bus", ibus_out, mem[a]);
        @(negedge clk); dr_drv_int = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int l);
        int n;
        lat = l;
        @(negedge clk); ibus_in = a; addr_ld = 1;
        @(negedge clk); addr_ld = 0; ibus_in = d; dr_ld_int = 1; wr_req = 1;
        settle();
        check("R7 busy after write request", busy, 1);
        check("R7 ext_wr after write request", ext_wr, 1);
        @(negedge clk); dr_ld_int = 0; wr_req = 0; dr_drv_ext = 1; #1;
        check("R4 ext_wdata_oe", ext_wdata_oe, 1);
        check("R2 write data on ext_wdata", ext_wdata, d);
        n = 1;
        for (int k = 0; k < 50; k++) begin
            settle();
            if (busy) n++; else break;
        end
        check("R8 busy length write", n, l + 1);
        check("R7 ext_wr dropped", ext_wr, 0);
        @(negedge clk); dr_drv_ext = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        check("R10 ext_addr reset", ext_addr, 0);
        check("R10 ext_wdata reset", ext_wdata, 0);
        check("R10 busy reset", busy, 0);
        check("R10 ext_rd reset", ext_rd, 0);
        check("R10 ext_wr reset", ext_wr, 0);
        check("R10 ctl_err reset", ctl_err, 0);
        check("R10 req_err reset", req_err, 0);

        // Register-transfer table (R1, R2, R3, R5).
        use_tbl = 1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {addr_ld, dr_ld_int, dr_drv_int, dr_ld_ext, dr_drv_ext} = VEC[v][37:33];
            ibus_in = VEC[v][32:25]; tbl_rdata = VEC[v][24:17];
            settle();
            check("R1 table ext_addr", ext_addr, VEC[v][16:9]);
            check("R2 R3 table data register", ext_wdata, VEC[v][8:1]);
            check("R5 table ctl_err", ctl_err, VEC[v][0]);
        end
        @(negedge clk);
        {addr_ld, dr_ld_int, dr_drv_int, dr_ld_ext, dr_drv_ext} = '0;
        use_tbl = 0;
        settle();
        check("R5 ctl_err single pulse", ctl_err, 0);

        // Drive and conflict at the internal bus (R4, R5).
        @(negedge clk); dr_drv_int = 1; #1;
        check("R4 ibus_oe", ibus_oe, 1);
        check("R4 ibus_out", ibus_out, 8'hC3);
        dr_ld_int = 1; ibus_in = 8'h44; #1;
        check("R5 no drive on clash", ibus_oe, 0);
        check("R4 ibus_out zero when not driving", ibus_out, 0);
        @(negedge clk); dr_drv_int = 0; dr_ld_int = 0;

        // Transfers with several latencies (R6, R7, R8).
        do_read(8'h10, 1);
        do_read(8'h21, 4);
        do_write(8'h33, 8'hBE, 3);
        do_read(8'h33, 2);
        do_write(8'h34, 8'h07, 1);
        do_read(8'h34, 1);

        // MFC while idle has no effect (R8).
        @(negedge clk); mfc_inj = 1;
        settle();
        check("R8 idle mfc busy", busy, 0);
        check("R8 idle mfc ext_rd", ext_rd, 0);
        @(negedge clk); mfc_inj = 0;

        // Request while busy is rejected (R9).
        lat = 4;
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0; wr_req = 1;
        settle();
        check("R9 req_err on busy request", req_err, 1);
        check("R9 no write command", ext_wr, 0);
        check("R9 read still open", ext_rd, 1);
        @(negedge clk); wr_req = 0;
        settle();
        check("R9 req_err single pulse", req_err, 0);
        for (int k = 0; k < 20 && busy; k++) settle();
        check("R9 busy closed", busy, 0);

        // Simultaneous requests while idle (R9).
        @(negedge clk); rd_req = 1; wr_req = 1;
        settle();
        check("R9 dual request flagged", req_err, 1);
        check("R9 dual request ignored", busy, 0);
        @(negedge clk); rd_req = 0; wr_req = 0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule